// File: doc/BRIEF.md
# Windowed Residual Chip Canceller

This block keeps the residual received signal for one user's cancellation unit in a circular window five symbols long. Each entry is one complex chip with signed 8-bit real and imaginary parts. Software does not load it. An upstream stage fills the window, and a regenerator supplies one interference image per propagation path. Each image is a vector of 16 complex chips, tagged with its path index. For each image the block takes the 16 chips that start at the window base plus that path's delay offset. It subtracts the image from them in 16 parallel saturating subtractors and writes the results back in place. When every path of the symbol has been handled, the window holds the residual that the next user's unit reads through the read port.

A small state machine runs each symbol's cancellation. Its states are IDLE, RUN, DRAIN and FIN. The transitions are:

- START_GO: IDLE to RUN, when `start` arrives with a nonzero path count.
- START_EMPTY: IDLE to FIN, when `start` arrives with a path count of zero.
- LAST_PATH: RUN to DRAIN, when the image that completes the count is accepted.
- FLUSH: DRAIN to FIN, always.
- RETIRE: FIN to IDLE, always.

Each accepted image spends one cycle in a read stage and is written back at the next edge. If the next path's segment overlaps chips that are still in flight, the read stage forwards the fresh results. This lets images arrive back to back, one per cycle, so a symbol with L paths takes L cycles plus two.

Between symbols the window base advances by one symbol (16 chips) modulo the window, so chips from earlier symbols stay available to later ones.

Top module: `residual_chip_canceller`

## Requirements
- R1: After reset every window chip reads as 0, the window base is 0, and `busy` and `done` are low.
- R2: In IDLE, `ld_en` writes the chip pair to absolute window address `ld_addr` (0 to 79). `rd_re`/`rd_im` show the chip at `rd_addr` combinationally.
- R3: Each chip update is residual minus image, computed separately for real and imaginary parts and clamped to [-128, 127]. There is no wrap-around.
- R4: An image accepted with path index p updates chip i (0 to 15) at window address (base + delay[p] + i) mod 80. Delay p occupies bits [7p+6:7p] of `path_dly`. Image chip i occupies bits [8i+7:8i] of `img_re` and `img_im`.
- R5: Images may arrive on consecutive cycles. An image whose segment overlaps chips written by the previous image uses the already-updated values, so the result equals applying the paths in acceptance order.
- R6: A `slide` pulse in IDLE advances the base by 16 modulo 80. Segment addresses wrap past address 79 to 0.
- R7: After the image that completes the path count is accepted, `done` is high for exactly one cycle, starting at the second following clock edge. The window then holds the final residual, and `busy` falls with `done`.
- R8: While busy, `ld_en` and `slide` have no effect. While idle, `img_vld` has no effect.
- R9: `start` with `num_paths` = 0 raises `done` at the next edge and leaves the window unchanged.
- R10: `start` while busy is ignored. The path count and progress of the running symbol are not altered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Load strobe for one window chip |
| ld_addr | input | 7 | Absolute window address for loads |
| ld_re | input | 8 | Real part to load (signed) |
| ld_im | input | 8 | Imaginary part to load (signed) |
| slide | input | 1 | Advance window base by one symbol |
| start | input | 1 | Begin cancellation for one symbol |
| num_paths | input | 3 | Number of path images to expect (0 to 6) |
| img_vld | input | 1 | Image vector valid |
| img_path | input | 3 | Path index of the image |
| img_re | input | 128 | Real parts of the 16 image chips |
| img_im | input | 128 | Imaginary parts of the 16 image chips |
| path_dly | input | 42 | Six 7-bit path delay offsets |
| rd_addr | input | 7 | Absolute window address to read |
| rd_re | output | 8 | Real part at `rd_addr` (signed) |
| rd_im | output | 8 | Imaginary part at `rd_addr` (signed) |
| busy | output | 1 | Symbol cancellation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong base pointer or a wrong address reduction moves every later update to the wrong chips. This shows at the read port in the first symbol after the fault. The bench finds it by comparing all 80 chips against a reference window after each symbol.

A missing forward or a stale read stage corrupts only the chips shared by overlapping back-to-back paths, so delays chosen to overlap and repeat are used.

A faulty path counter shows within one symbol as a `done` pulse at the wrong edge. A saturation error appears as wrapped values at the extreme chips.

// File: rtl/rcc_pkg.sv
package rcc_pkg;

    localparam int CW = 8;

    typedef struct packed {
        logic signed [CW-1:0] re;
        logic signed [CW-1:0] im;
    } chip_t;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_RUN   = 2'd1,
        S_DRAIN = 2'd2,
        S_FIN   = 2'd3
    } rcc_state_t;

    function automatic logic signed [CW-1:0] sat_sub(
        input logic signed [CW-1:0] a,
        input logic signed [CW-1:0] b
    );
        logic signed [CW:0] diff;
        diff = {a[CW-1], a} - {b[CW-1], b};
        if (diff > $signed({2'b00, {(CW-1){1'b1}}}))
            sat_sub = {1'b0, {(CW-1){1'b1}}};
        else if (diff < $signed({2'b11, {(CW-1){1'b0}}}))
            sat_sub = {1'b1, {(CW-1){1'b0}}};
        else
            sat_sub = diff[CW-1:0];
    endfunction

endpackage

// File: rtl/rcc_ctrl.sv
module rcc_ctrl
    import rcc_pkg::*;
#(
    parameter int LMAX = 6,
    localparam int PW = $clog2(LMAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [PW-1:0] num_paths,
    input  logic          img_vld,
    output logic          busy,
    output logic          done,
    output logic          accept
);

    rcc_state_t    state, nxt;
    logic [PW-1:0] cnt;
    logic [PW-1:0] tgt;
    logic          last_img;

    assign last_img = (state == S_RUN) && img_vld && (cnt == tgt - PW'(1));

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (start) nxt = (num_paths == '0) ? S_FIN : S_RUN;
            S_RUN:   if (last_img) nxt = S_DRAIN;
            S_DRAIN: nxt = S_FIN;
            S_FIN:   nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            cnt   <= '0;
            tgt   <= '0;
        end else begin
            state <= nxt;
            if (state == S_IDLE && start) begin
                cnt <= '0;
                tgt <= (num_paths > PW'(LMAX)) ? PW'(LMAX) : num_paths;
            end else if (accept) begin
                cnt <= cnt + PW'(1);
            end
        end
    end

    always_comb begin
        busy   = (state != S_IDLE);
        done   = (state == S_FIN);
        accept = (state == S_RUN) && img_vld;
    end

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_timing_r7: assert property (@(posedge clk) disable iff (!rst_n)
        last_img |=> ##1 done);
    p_done_ends_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    p_zero_paths_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && num_paths == '0) |=> done);
    p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

endmodule

// File: rtl/rcc_addr_gen.sv
module rcc_addr_gen #(
    parameter int SF    = 16,
    parameter int DEPTH = 80,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic [AW-1:0]         base,
    input  logic [AW-1:0]         dly,
    output logic [SF-1:0][AW-1:0] addr
);

    localparam logic [AW+1:0] DEP = (AW+2)'(DEPTH);

    for (genvar i = 0; i < SF; i++) begin : g_lane
        logic [AW+1:0] sum;
        always_comb begin
            sum = {2'b00, base} + {2'b00, dly} + (AW+2)'(i);
            if (sum >= DEP) sum = sum - DEP;
            if (sum >= DEP) sum = sum - DEP;
            addr[i] = sum[AW-1:0];
        end
    end

endmodule

// File: rtl/rcc_sub_bank.sv
module rcc_sub_bank
    import rcc_pkg::*;
#(
    parameter int SF = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  chip_t [SF-1:0]   res,
    input  chip_t [SF-1:0]   img,
    output chip_t [SF-1:0]   out
);

    for (genvar i = 0; i < SF; i++) begin : g_sub
        always_comb begin
            out[i].re = sat_sub(res[i].re, img[i].re);
            out[i].im = sat_sub(res[i].im, img[i].im);
        end

        p_sat_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
            ($signed(res[i].re) >= 0 && $signed(img[i].re) < 0) |-> $signed(out[i].re) >= 0);
        p_sat_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
            ($signed(res[i].im) < 0 && $signed(img[i].im) > 0) |-> $signed(out[i].im) < 0);
    end

endmodule

// File: rtl/residual_chip_canceller.sv
module residual_chip_canceller
    import rcc_pkg::*;
#(
    parameter int SF       = 16,
    parameter int WIN_SYMS = 5,
    parameter int LMAX     = 6,
    localparam int DEPTH   = SF * WIN_SYMS,
    localparam int AW      = $clog2(DEPTH),
    localparam int PW      = $clog2(LMAX + 1),
    localparam int IW      = $clog2(LMAX)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld_en,
    input  logic [AW-1:0]        ld_addr,
    input  logic signed [CW-1:0] ld_re,
    input  logic signed [CW-1:0] ld_im,
    input  logic                 slide,
    input  logic                 start,
    input  logic [PW-1:0]        num_paths,
    input  logic                 img_vld,
    input  logic [IW-1:0]        img_path,
    input  logic [SF*CW-1:0]     img_re,
    input  logic [SF*CW-1:0]     img_im,
    input  logic [LMAX*AW-1:0]   path_dly,
    input  logic [AW-1:0]        rd_addr,
    output logic signed [CW-1:0] rd_re,
    output logic signed [CW-1:0] rd_im,
    output logic                 busy,
    output logic                 done
);

    localparam logic [AW-1:0] DEP_A = AW'(DEPTH);
    localparam logic [AW:0]   SF_W  = (AW+1)'(SF);

    chip_t                mem [DEPTH];
    logic [AW-1:0]        base;
    logic                 accept;
    logic [AW-1:0]        sel_dly;
    logic [SF-1:0][AW-1:0] seg_addr;
    chip_t [SF-1:0]       img_v;
    chip_t [SF-1:0]       fwd;
    chip_t [SF-1:0]       sub_out;

    logic                  s1_vld;
    logic [SF-1:0][AW-1:0] s1_addr;
    chip_t [SF-1:0]        s1_res;
    chip_t [SF-1:0]        s1_img;

    rcc_ctrl #(.LMAX(LMAX)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .num_paths (num_paths),
        .img_vld   (img_vld),
        .busy      (busy),
        .done      (done),
        .accept    (accept)
    );

    always_comb begin
        sel_dly = '0;
        for (int p = 0; p < LMAX; p++)
            if (img_path == IW'(p)) sel_dly = path_dly[p*AW +: AW];
    end

    rcc_addr_gen #(.SF(SF), .DEPTH(DEPTH)) u_addr (
        .base (base),
        .dly  (sel_dly),
        .addr (seg_addr)
    );

    for (genvar i = 0; i < SF; i++) begin : g_unpack
        assign img_v[i].re = img_re[i*CW +: CW];
        assign img_v[i].im = img_im[i*CW +: CW];
    end

    rcc_sub_bank #(.SF(SF)) u_sub (
        .clk   (clk),
        .rst_n (rst_n),
        .res   (s1_res),
        .img   (s1_img),
        .out   (sub_out)
    );

    // read stage: fetch segment, take in-flight results where addresses collide
    always_comb begin
        for (int i = 0; i < SF; i++) begin
            fwd[i] = mem[seg_addr[i]];
            for (int j = 0; j < SF; j++)
                if (s1_vld && s1_addr[j] == seg_addr[i]) fwd[i] = sub_out[j];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld  <= 1'b0;
            s1_addr <= '0;
            s1_res  <= '0;
            s1_img  <= '0;
        end else begin
            s1_vld <= accept;
            if (accept) begin
                s1_addr <= seg_addr;
                s1_res  <= fwd;
                s1_img  <= img_v;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
        end else begin
            if (ld_en && !busy && ld_addr < DEP_A) begin
                mem[ld_addr].re <= ld_re;
                mem[ld_addr].im <= ld_im;
            end
            if (s1_vld)
                for (int i = 0; i < SF; i++) mem[s1_addr[i]] <= sub_out[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base <= '0;
        end else if (slide && !busy) begin
            if ({1'b0, base} + SF_W >= (AW+1)'(DEPTH))
                base <= AW'({1'b0, base} + SF_W - (AW+1)'(DEPTH));
            else
                base <= base + AW'(SF);
        end
    end

    always_comb begin
        if (rd_addr < DEP_A) begin
            rd_re = mem[rd_addr].re;
            rd_im = mem[rd_addr].im;
        end else begin
            rd_re = '0;
            rd_im = '0;
        end
    end

    p_base_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (slide && !busy) |=> ({1'b0, base} == (({1'b0, $past(base)} + SF_W) % (AW+1)'(DEPTH))));
    p_base_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(base));
    p_load_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && !busy && !s1_vld && ld_addr < DEP_A) |=> (mem[$past(ld_addr)].re == $past(ld_re)));
    p_no_write_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !s1_vld);

endmodule

// File: tb/tb_residual_chip_canceller.sv
module tb_residual_chip_canceller;

    localparam int SF = 16, DEPTH = 80, AW = 7, LMAX = 6, CW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ld_en = 1'b0, slide = 1'b0, start = 1'b0, img_vld = 1'b0;
    logic [AW-1:0] ld_addr = '0, rd_addr = '0;
    logic signed [CW-1:0] ld_re = '0, ld_im = '0;
    logic [2:0] num_paths = '0, img_path = '0;
    logic [SF*CW-1:0] img_re = '0, img_im = '0;
    logic [LMAX*AW-1:0] path_dly = '0;
    logic signed [CW-1:0] rd_re, rd_im;
    logic busy, done;

    residual_chip_canceller dut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr), .ld_re(ld_re),
        .ld_im(ld_im), .slide(slide), .start(start), .num_paths(num_paths),
        .img_vld(img_vld), .img_path(img_path), .img_re(img_re), .img_im(img_im),
        .path_dly(path_dly), .rd_addr(rd_addr), .rd_re(rd_re), .rd_im(rd_im),
        .busy(busy), .done(done)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    int mre [DEPTH];
    int mim [DEPTH];
    int mbase = 0;
    int ir [LMAX][SF];
    int ii [LMAX][SF];
    int dl [LMAX];

    function automatic int sat(input int v);
        if (v > 127) return 127;
        if (v < -128) return -128;
        return v;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_mem(input string tag);
        for (int a = 0; a < DEPTH; a++) begin
            rd_addr = AW'(a);
            #1;
            chk(tag, int'(rd_re), mre[a]);
            chk(tag, int'(rd_im), mim[a]);
        end
    endtask

    task automatic load(input int a, input int re, input int im);
        ld_en = 1'b1; ld_addr = AW'(a); ld_re = CW'(re); ld_im = CW'(im);
        @(negedge clk);
        ld_en = 1'b0;
        mre[a] = re; mim[a] = im;
    endtask

    task automatic do_slide();
        slide = 1'b1;
        @(negedge clk);
        slide = 1'b0;
        mbase = (mbase + SF) % DEPTH;
    endtask

    task automatic fill_imgs(input int dmax);
        for (int k = 0; k < LMAX; k++) begin
            dl[k] = $urandom % dmax;
            for (int i = 0; i < SF; i++) begin
                ir[k][i] = int'($signed(8'($urandom)));
                ii[k][i] = int'($signed(8'($urandom)));
            end
        end
    endtask

    // disturb: try a load, a slide and a second start while the symbol runs
    task automatic run_cancel(input int np, input bit disturb, input string tag);
        for (int k = 0; k < LMAX; k++) path_dly[k*AW +: AW] = AW'(dl[k]);
        start = 1'b1; num_paths = 3'(np);
        @(negedge clk);
        start = 1'b0;
        if (np == 0) begin
            chk("R9 done after empty start", int'(done), 1);
            @(negedge clk);
            chk("R9 idle again", int'(busy), 0);
            return;
        end
        chk({tag, " busy"}, int'(busy), 1);
        if (disturb) begin
            ld_en = 1'b1; ld_addr = 7'd3; ld_re = 8'sd55; ld_im = -8'sd55;
            slide = 1'b1;
            @(negedge clk);
            ld_en = 1'b0; slide = 1'b0;
        end
        for (int k = 0; k < np; k++) begin
            img_vld = 1'b1; img_path = 3'(k);
            if (disturb && k == 0) begin start = 1'b1; num_paths = 3'd6; end
            for (int i = 0; i < SF; i++) begin
                img_re[i*CW +: CW] = CW'(ir[k][i]);
                img_im[i*CW +: CW] = CW'(ii[k][i]);
            end
            @(negedge clk);
            start = 1'b0;
            for (int i = 0; i < SF; i++) begin
                int a;
                a = (mbase + dl[k] + i) % DEPTH;
                mre[a] = sat(mre[a] - ir[k][i]);
                mim[a] = sat(mim[a] - ii[k][i]);
            end
        end
        img_vld = 1'b0;
        chk("R7 done low one edge after last image", int'(done), 0);
        @(negedge clk);
        chk("R7 done high two edges after last image", int'(done), 1);
        @(negedge clk);
        chk("R7 done single cycle", int'(done), 0);
        chk("R7 busy falls", int'(busy), 0);
        check_mem(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20417));
        for (int a = 0; a < DEPTH; a++) begin mre[a] = 0; mim[a] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        check_mem("R1 window zero");

        for (int a = 0; a < DEPTH; a++)
            load(a, int'($signed(8'($urandom))), int'($signed(8'($urandom))));
        check_mem("R2 load and read");

        // saturation corners at address 0 and 1 (base 0, delay 0)
        load(0, 100, -100);
        load(1, -100, 100);
        fill_imgs(DEPTH);
        dl[0] = 0;
        ir[0][0] = -100; ii[0][0] = 100;
        ir[0][1] = 100;  ii[0][1] = -100;
        run_cancel(1, 1'b0, "R3 R4 single path");
        rd_addr = 7'd0; #1;
        chk("R3 clamp high", int'(rd_re), 127);
        chk("R3 clamp low", int'(rd_im), -128);
        rd_addr = 7'd1; #1;
        chk("R3 clamp low", int'(rd_re), -128);
        chk("R3 clamp high", int'(rd_im), 127);

        // overlapping back-to-back paths
        fill_imgs(DEPTH);
        dl[0] = 10; dl[1] = 14; dl[2] = 14; dl[3] = 25;
        run_cancel(4, 1'b0, "R5 overlap forwarding");

        // slide to base 64, segments wrap past 79
        repeat (4) do_slide();
        fill_imgs(DEPTH);
        dl[0] = 10; dl[1] = 0; dl[2] = 79;
        run_cancel(3, 1'b0, "R6 wrap after slide");
        do_slide();
        fill_imgs(DEPTH);
        dl[0] = 0;
        run_cancel(1, 1'b0, "R6 base back to zero");

        run_cancel(0, 1'b0, "R9");
        check_mem("R9 window unchanged");

        fill_imgs(DEPTH);
        run_cancel(2, 1'b1, "R8 R10 disturbed symbol");

        img_vld = 1'b1; img_path = 3'd0;
        for (int i = 0; i < SF; i++) begin img_re[i*CW +: CW] = 8'sd77; img_im[i*CW +: CW] = 8'sd77; end
        @(negedge clk);
        img_vld = 1'b0;
        @(negedge clk);
        check_mem("R8 image in idle ignored");

        for (int it = 0; it < 12; it++) begin
            if ($urandom % 2) do_slide();
            if ($urandom % 2)
                load($urandom % DEPTH, int'($signed(8'($urandom))), int'($signed(8'($urandom))));
            fill_imgs(($urandom % 2) ? 20 : DEPTH);
            run_cancel(1 + ($urandom % LMAX), 1'b0, "R4 R5 random symbol");
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule